// File: doc/BRIEF.md
# Soft Reset and Clock-Gate Controller

This block is the control register that owns the reset and clock enable of one peripheral core. Software reaches the register through a small register bus. The same register appears at three offsets: one offset replaces the value, one sets bits and one clears bits. The top two bits of the register are a soft-reset bit and a clock-gate bit. The remaining low bits are a configuration field that is passed to the core.

Setting the soft-reset bit holds the core in reset, returns the configuration field to its default and gates the core clock automatically. Software can poll the clock-gate bit to see that the gating has happened. Releasing soft reset does not happen at once. The bit keeps reading 1 for a settle window of several cycles, and only then does the core leave reset. Two procedures use these bits. Software enables the core without disturbing its configuration by clearing soft reset and then clearing the clock gate. It resets the core fully by asserting soft reset, waiting for the gate bit to read 1, and then doing the enable steps.

Top module: `srcg_ctrl`

## Requirements
- R1: After hardware reset, the register reads soft-reset = 1 (bit 31), clock-gate = 1 (bit 30), bits 29..16 = 0 and the configuration field (bits 15..0) = its default value (0x00A5). core_rst is 1, core_clk_en is 0 and core_cfg equals the default.
- R2: A write at offset 0x0 replaces the register with the written data, subject to R6 to R9.
- R3: A write at offset 0x4 sets every register bit that is 1 in the written data and leaves the other bits unchanged.
- R4: A write at offset 0x8 clears every register bit that is 1 in the written data and leaves the other bits unchanged.
- R5: A write at offset 0xC changes nothing.
- R6: When a write sets bit 31, the next read shows bits 31 and 30 both at 1. From that point core_rst is 1, core_clk_en is 0 and the configuration field returns to its default.
- R7: When a write clears bit 31, bit 31 and core_rst stay at 1 through SETTLE (3) clock edges, counting the write edge. They fall to 0 on the edge after that.
- R8: While bit 31 reads 1, the clock-gate bit cannot be cleared and the configuration field stays at its default, whatever is written.
- R9: core_clk_en is 0 whenever bit 30 reads 1. While the clock is gated, writes to the configuration field are ignored and it keeps its value.
- R10: The enable-only procedure leaves the configuration field unchanged. In this procedure software clears bit 31 and then clears bit 30.
- R11: The full-reset procedure ends with soft reset and gate both at 0, core_clk_en at 1 and the configuration field at its default.
- R12: Setting bit 31 while a release is settling cancels that release, and bit 31 stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low hardware reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Byte offset that selects the alias |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Current register value |
| core_rst | output | 1 | Synchronous reset to the peripheral core |
| core_clk_en | output | 1 | Clock enable for the peripheral core |
| core_cfg | output | 16 | Configuration field driven to the core |

## Verification
The alias decoding is exercised by acting on the same configuration value through the replace, set, clear and unused offsets. Each write is chosen so that the result tells a merge apart from an overwrite. The release timing is sampled on the last edge where bit 31 must still be 1 and on the first edge where it must be 0, so an off-by-one in the settle count is seen. Writes to the configuration field are sent while the clock is gated and again while the core is in reset, which shows whether each blocking rule applies. A repeated set of bit 31 during settling shows whether a pending release is cancelled.

// File: rtl/srcg_pkg.sv
package srcg_pkg;

    localparam int DATA_W   = 32;
    localparam int SRST_BIT = 31;
    localparam int GATE_BIT = 30;

    typedef enum logic [1:0] {
        ALIAS_WRITE = 2'd0,
        ALIAS_SET   = 2'd1,
        ALIAS_CLEAR = 2'd2,
        ALIAS_NONE  = 2'd3
    } alias_e;

    function automatic alias_e alias_of(input logic [3:0] offs);
        case (offs)
            4'h0:    return ALIAS_WRITE;
            4'h4:    return ALIAS_SET;
            4'h8:    return ALIAS_CLEAR;
            default: return ALIAS_NONE;
        endcase
    endfunction

endpackage

// File: rtl/srcg_alias_dec.sv
module srcg_alias_dec
    import srcg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cur,
    output logic              wr_hit,
    output logic [DATA_W-1:0] set_m,
    output logic [DATA_W-1:0] clr_m,
    output logic [DATA_W-1:0] merged
);

    alias_e kind;

    always_comb begin
        kind  = alias_of(addr[3:0]);
        set_m = '0;
        clr_m = '0;
        if (wr) begin
            case (kind)
                ALIAS_WRITE: begin
                    set_m = wdata;
                    clr_m = ~wdata;
                end
                ALIAS_SET:   set_m = wdata;
                ALIAS_CLEAR: clr_m = wdata;
                default: ;
            endcase
        end
        wr_hit = wr && (kind != ALIAS_NONE);
        merged = (cur & ~clr_m) | set_m;
    end

    assert_set_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && kind == ALIAS_SET) |-> ((merged & cur) == cur));

    assert_clear_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && kind == ALIAS_CLEAR) |-> ((merged & wdata) == '0));

    assert_idle_alias_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ALIAS_NONE) |-> (!wr_hit && merged == cur));

endmodule

// File: rtl/srcg_settle_cnt.sv
module srcg_settle_cnt #(
    parameter int SETTLE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic done
);

    localparam int CNT_W = $clog2(SETTLE + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (abort)              cnt_d = '0;
        else if (start)         cnt_d = CNT_LOAD;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
        busy = (cnt_q != '0);
        done = (cnt_q == CNT_W'(1)) && !abort;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LOAD);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !busy);

    assert_abort_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);

endmodule

// File: rtl/srcg_ctrl.sv
module srcg_ctrl
    import srcg_pkg::*;
#(
    parameter int                ADDR_W      = 4,
    parameter int                CFG_W       = 16,
    parameter logic [CFG_W-1:0]  CFG_DEFAULT = CFG_W'(16'h00A5),
    parameter int                SETTLE      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              core_rst,
    output logic              core_clk_en,
    output logic [CFG_W-1:0]  core_cfg
);

    localparam int PAD_W = GATE_BIT - CFG_W;

    typedef struct packed {
        logic             srst;
        logic             gate;
        logic [CFG_W-1:0] cfg;
    } regs_t;

    regs_t s_d, s_q;

    logic              wr_hit;
    logic [DATA_W-1:0] set_m, clr_m, merged, cur_word;
    logic              settle_start, settle_abort, settle_busy, settle_done;
    logic              assert_req;

    always_comb begin
        cur_word = {s_q.srst, s_q.gate, {PAD_W{1'b0}}, s_q.cfg};
    end

    srcg_alias_dec #(
        .ADDR_W (ADDR_W)
    ) i_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .cur    (cur_word),
        .wr_hit (wr_hit),
        .set_m  (set_m),
        .clr_m  (clr_m),
        .merged (merged)
    );

    srcg_settle_cnt #(
        .SETTLE (SETTLE)
    ) i_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .start (settle_start),
        .abort (settle_abort),
        .busy  (settle_busy),
        .done  (settle_done)
    );

    always_comb begin
        s_d          = s_q;
        assert_req   = wr_hit && set_m[SRST_BIT];
        settle_start = 1'b0;
        settle_abort = 1'b0;

        if (assert_req) begin
            s_d.srst     = 1'b1;
            s_d.gate     = 1'b1;
            settle_abort = 1'b1;
        end else if (wr_hit && clr_m[SRST_BIT] && s_q.srst && !settle_busy) begin
            settle_start = 1'b1;
        end

        if (settle_done && !assert_req) s_d.srst = 1'b0;

        if (!s_q.srst && !assert_req && wr_hit) s_d.gate = merged[GATE_BIT];

        if (s_q.srst || assert_req) begin
            s_d.cfg = CFG_DEFAULT;
        end else if (wr_hit && !s_q.gate) begin
            s_d.cfg = merged[CFG_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.srst <= 1'b1;
            s_q.gate <= 1'b1;
            s_q.cfg  <= CFG_DEFAULT;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_rdata   = cur_word;
        core_rst    = s_q.srst;
        core_clk_en = !s_q.gate;
        core_cfg    = s_q.cfg;
    end

    assert_auto_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && set_m[SRST_BIT]) |=> (core_rst && !core_clk_en && bus_rdata[GATE_BIT]));

    assert_release_settled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.srst) |-> $past(settle_done));

    assert_gate_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.srst |-> s_q.gate);

    assert_cfg_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.srst |=> (core_cfg == CFG_DEFAULT));

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.gate && !s_q.srst && !(wr_hit && set_m[SRST_BIT])) |=> $stable(core_cfg));

    assert_rearm_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_busy && wr_hit && set_m[SRST_BIT]) |=> (core_rst && !settle_busy));

endmodule

// File: tb/test_srcg_ctrl.sv
module test_srcg_ctrl;

    localparam int        SETTLE = 3;
    localparam logic [15:0] DEF  = 16'h00A5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_rst, core_clk_en;
    logic [15:0] core_cfg;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    srcg_ctrl #(.SETTLE(SETTLE)) i_srcg_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .core_rst    (core_rst),
        .core_clk_en (core_clk_en),
        .core_cfg    (core_cfg)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rdata", bus_rdata, {16'hC000, DEF});
        chk("R1 core_rst", {31'b0, core_rst}, 32'd1);
        chk("R1 clk_en", {31'b0, core_clk_en}, 32'd0);
        chk("R1 core_cfg", {16'b0, core_cfg}, {16'b0, DEF});
    endtask

    task automatic t_enable_first();
        wr(4'h8, 32'h8000_0000);
        chk("R7 held after write edge", {31'b0, bus_rdata[31]}, 32'd1);
        repeat (SETTLE - 1) @(negedge clk);
        chk("R7 held on last settle edge", {31'b0, core_rst}, 32'd1);
        @(negedge clk);
        chk("R7 released", {31'b0, bus_rdata[31]}, 32'd0);
        chk("R7 core_rst low", {31'b0, core_rst}, 32'd0);
        wr(4'h8, 32'h4000_0000);
        chk("R9 clk_en after ungate", {31'b0, core_clk_en}, 32'd1);
        chk("R10 cfg kept", bus_rdata, {16'h0000, DEF});
    endtask

    task automatic t_aliases();
        wr(4'h0, 32'h0000_1234);
        chk("R2 plain write", bus_rdata, 32'h0000_1234);
        wr(4'h4, 32'h0000_00F0);
        chk("R3 set alias", bus_rdata, 32'h0000_12F4);
        wr(4'h8, 32'h0000_1004);
        chk("R4 clear alias", bus_rdata, 32'h0000_02F0);
        wr(4'hC, 32'hFFFF_FFFF);
        chk("R5 unused offset", bus_rdata, 32'h0000_02F0);
        chk("R5 no reset", {31'b0, core_rst}, 32'd0);
    endtask

    task automatic t_gate();
        wr(4'h4, 32'h4000_0000);
        chk("R9 gate bit", bus_rdata, 32'h4000_02F0);
        chk("R9 clk_en low", {31'b0, core_clk_en}, 32'd0);
        wr(4'h0, 32'h4000_5555);
        chk("R9 cfg write ignored", {16'b0, core_cfg}, 32'h0000_02F0);
        wr(4'h8, 32'h8000_0000);
        chk("R10 clear srst when idle", bus_rdata, 32'h4000_02F0);
        wr(4'h8, 32'h4000_0000);
        chk("R10 cfg kept after enable", bus_rdata, 32'h0000_02F0);
        chk("R10 clk_en", {31'b0, core_clk_en}, 32'd1);
    endtask

    task automatic t_full_reset();
        wr(4'h4, 32'h8000_0000);
        chk("R6 both bits set", bus_rdata, {16'hC000, DEF});
        chk("R6 core_rst", {31'b0, core_rst}, 32'd1);
        chk("R6 clk_en", {31'b0, core_clk_en}, 32'd0);
        wr(4'h0, 32'h8000_1111);
        chk("R8 gate held", {31'b0, bus_rdata[30]}, 32'd1);
        chk("R8 cfg default", {16'b0, core_cfg}, {16'b0, DEF});
        wr(4'h8, 32'h8000_0000);
        repeat (SETTLE - 1) @(negedge clk);
        chk("R7 held in full reset", {31'b0, bus_rdata[31]}, 32'd1);
        @(negedge clk);
        chk("R7 released in full reset", {31'b0, bus_rdata[31]}, 32'd0);
        wr(4'h8, 32'h4000_0000);
        chk("R11 final value", bus_rdata, {16'h0000, DEF});
        chk("R11 clk_en", {31'b0, core_clk_en}, 32'd1);
        chk("R11 core_rst", {31'b0, core_rst}, 32'd0);
    endtask

    task automatic t_rearm();
        wr(4'h4, 32'h8000_0000);
        wr(4'h8, 32'h8000_0000);
        wr(4'h4, 32'h8000_0000);
        repeat (SETTLE + 4) @(negedge clk);
        chk("R12 stays in reset", {31'b0, bus_rdata[31]}, 32'd1);
        chk("R12 core_rst", {31'b0, core_rst}, 32'd1);
        wr(4'h8, 32'h8000_0000);
        repeat (SETTLE) @(negedge clk);
        chk("R12 later release", {31'b0, bus_rdata[31]}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_first();
        t_aliases();
        t_gate();
        t_full_reset();
        t_rearm();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule